// File: doc/BRIEF.md
# Partitioned SIMD Vector ALU

This block runs one arithmetic, logic or shift operation across two vector registers and writes the answer into a third. A vector is `LANES` 32-bit lanes wide, and `LANES` must be even. A 2-bit length field picks the element size: 8, 16, 32 or 64 bits. The same adder, logic and shift hardware serves all four sizes. The element boundaries decide where a carry, a borrow or a shifted bit must stop. In 64-bit mode the carry runs from the low lane of each lane pair into the high lane. In 8-bit and 16-bit mode it is cut inside a lane.

Instructions arrive as 20-bit vector fields on a valid/ready stream. A 16-entry vector register file sits inside the block. It has a load port, so operands can be placed in it, and a read port, so results can be inspected. Each written result also appears for one cycle on a writeback output. The block applies back-pressure in exactly one case: `in_ready` falls while the load port is active. While `in_ready` is low, an instruction held on `in_valid` stays pending and is not consumed. A dependent instruction may issue in the very next cycle, because a result still in flight is forwarded to the operand inputs.

Top module: `simd_valu`

## Requirements
- R1: An instruction field is an ALU operation when bits [19:18] = 01. Its other fields are: bits [17:16] element length, bits [15:12] operation, bits [11:8] destination, bits [7:4] first source (A), bits [3:0] second source (B).
- R2: Length code 00 selects 8-bit elements, 01 selects 16, 10 selects 32 and 11 selects 64. Operation 0000 adds A and B. Each element wraps modulo its own size, and no carry enters the next element.
- R3: Operation 0010 computes A minus B in each element. The result wraps, and no borrow crosses an element boundary.
- R4: With length 11, the carry or borrow passes from lane 2i into lane 2i+1. It never passes from lane 2i+1 into lane 2i+2.
- R5: Operations 1000 (AND), 1001 (OR) and 1010 (XOR) act bitwise. They give the same result at every element length.
- R6: Operation 1100 shifts each element of A left by one bit. The vacated bit is filled with zero, and the bit shifted out of each element is dropped.
- R7: Operation 1110 shifts each element of A right by one bit. The vacated top bit is filled with zero, and the bit shifted out is dropped.
- R8: An accepted field that writes nothing leaves every register unchanged and raises no writeback. This covers bits [19:18] of 00, 10 or 11. It also covers operation codes 0001, 0011–0111, 1011 (multiply is not built), 1101 and 1111.
- R9: An ALU instruction accepted at clock edge n drives `wb_valid`, `wb_idx` and `wb_data` after edge n. The destination register shows the new value on `rd_data` after edge n+1.
- R10: An instruction accepted in the cycle after another one reads that instruction's result whenever it names the same register as a source.
- R11: `in_ready` is low exactly when `ld_en` is high, and a held instruction is taken only after the load ends. The load writes `ld_data` to register `ld_idx` on the clock edge. When a load and a pending writeback hit the same register on the same edge, the load wins.
- R12: After reset every register reads zero and `wb_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction field is offered |
| in_ready | output | 1 | Block takes the field on this edge (low during a load) |
| in_instr | input | 20 | Vector instruction field |
| ld_en | input | 1 | Load `ld_data` into a register |
| ld_idx | input | 4 | Register loaded |
| ld_data | input | LANES*32 | Load value |
| rd_idx | input | 4 | Register shown on `rd_data` |
| rd_data | output | LANES*32 | Contents of register `rd_idx` |
| wb_valid | output | 1 | A result is being written back |
| wb_idx | output | 4 | Destination of the result |
| wb_data | output | LANES*32 | The result |

## Verification
The operands put all-ones words next to single ones, so carries and borrows pile up on every byte, halfword, lane and lane-pair boundary. A design that let a carry leak into a neighbouring element, or that failed to chain the two lanes of a 64-bit element, would show wrong digits exactly at those joints. The bench also checks three other things:
- Shift results are checked at every length, which catches a design that pulls a neighbour's bit into the vacated position.
- A chain of back-to-back dependent instructions checks operand forwarding. Without it, the chain would read stale register values.
- Reserved operation codes and non-ALU fields must leave registers alone. A stalled instruction must wait out a load, and a load that collides with a writeback must win. A design that got any of these wrong would show a stray writeback or a wrong register value on read-back.

// File: rtl/simd_pkg.sv
package simd_pkg;

  localparam int LANE_W    = 32;
  localparam int PAIR_W    = 2 * LANE_W;
  localparam int REG_IDX_W = 4;
  localparam int NREGS     = 1 << REG_IDX_W;
  localparam int FIELD_W   = 20;

  typedef enum logic [1:0] {
    WL_8  = 2'b00,
    WL_16 = 2'b01,
    WL_32 = 2'b10,
    WL_64 = 2'b11
  } wlen_t;

  typedef enum logic [2:0] {
    K_ADD,
    K_SUB,
    K_AND,
    K_OR,
    K_XOR,
    K_SHL,
    K_SHR
  } kind_t;

  typedef struct packed {
    logic                 wr;
    wlen_t                wl;
    kind_t                kind;
    logic [REG_IDX_W-1:0] dst;
    logic [REG_IDX_W-1:0] src_a;
    logic [REG_IDX_W-1:0] src_b;
  } uop_t;

endpackage

// File: rtl/simd_decode.sv
module simd_decode
  import simd_pkg::*;
(
  input  logic [FIELD_W-1:0] field,
  output uop_t               uop
);

  logic is_alu;
  assign is_alu = (field[19:18] == 2'b01);

  always_comb begin
    uop.wl    = wlen_t'(field[17:16]);
    uop.dst   = field[11:8];
    uop.src_a = field[7:4];
    uop.src_b = field[3:0];
    uop.kind  = K_ADD;
    uop.wr    = 1'b0;
    case (field[15:12])
      4'b0000: begin uop.kind = K_ADD; uop.wr = is_alu; end
      4'b0010: begin uop.kind = K_SUB; uop.wr = is_alu; end
      4'b1000: begin uop.kind = K_AND; uop.wr = is_alu; end
      4'b1001: begin uop.kind = K_OR;  uop.wr = is_alu; end
      4'b1010: begin uop.kind = K_XOR; uop.wr = is_alu; end
      4'b1100: begin uop.kind = K_SHL; uop.wr = is_alu; end
      4'b1110: begin uop.kind = K_SHR; uop.wr = is_alu; end
      default: begin uop.kind = K_ADD; uop.wr = 1'b0;   end
    endcase
  end

endmodule

// File: rtl/simd_vrf.sv
module simd_vrf
  import simd_pkg::*;
#(
  parameter int VW = 128
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [REG_IDX_W-1:0] ra_idx,
  output logic [VW-1:0]        ra_data,
  input  logic [REG_IDX_W-1:0] rb_idx,
  output logic [VW-1:0]        rb_data,
  input  logic [REG_IDX_W-1:0] rc_idx,
  output logic [VW-1:0]        rc_data,
  input  logic                 wr_en,
  input  logic [REG_IDX_W-1:0] wr_idx,
  input  logic [VW-1:0]        wr_data,
  input  logic                 ld_en,
  input  logic [REG_IDX_W-1:0] ld_idx,
  input  logic [VW-1:0]        ld_data
);

  logic [VW-1:0] mem [NREGS];

  assign ra_data = mem[ra_idx];
  assign rb_data = mem[rb_idx];
  assign rc_data = mem[rc_idx];

  // load is written last so it takes precedence on a same-index collision
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) mem[i] <= '0;
    end else begin
      if (wr_en) mem[wr_idx] <= wr_data;
      if (ld_en) mem[ld_idx] <= ld_data;
    end
  end

  assert_wb_lands_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !(ld_en && ld_idx == wr_idx)) |=> mem[$past(wr_idx)] == $past(wr_data));

  assert_load_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> mem[$past(ld_idx)] == $past(ld_data));

endmodule

// File: rtl/simd_pair.sv
module simd_pair
  import simd_pkg::*;
(
  input  wlen_t             wl,
  input  kind_t             kind,
  input  logic [PAIR_W-1:0] a,
  input  logic [PAIR_W-1:0] b,
  output logic [PAIR_W-1:0] y
);

  localparam int NB  = PAIR_W / 8;
  localparam int BIW = $clog2(NB);

  logic [BIW-1:0]    bmask;
  logic [NB-1:0]     st;     // byte starts an element
  logic [NB-1:0]     tp;     // byte ends an element
  logic [NB-1:0]     prv;    // bit entering a left shift
  logic [NB-1:0]     nxt;    // bit entering a right shift
  logic [NB-1:0]     cy;     // carry into each byte
  logic [PAIR_W-1:0] sum, shl, shr;
  logic              sub;

  assign sub   = (kind == K_SUB);
  assign bmask = BIW'((1 << wl) - 1);
  assign cy[0] = 1'b0;

  for (genvar j = 0; j < NB; j++) begin : g_byte
    logic [7:0] bo;
    logic       ci;

    assign st[j] = ((BIW'(j) & bmask) == '0);

    if (j == 0) begin : g_first
      assign prv[j] = 1'b0;
    end else begin : g_mid_lo
      assign prv[j] = a[8*j-1];
    end

    if (j == NB - 1) begin : g_last
      assign tp[j]  = 1'b1;
      assign nxt[j] = 1'b0;
    end else begin : g_mid_hi
      assign tp[j]  = st[j+1];
      assign nxt[j] = a[8*j+8];
    end

    assign bo = sub ? ~b[8*j +: 8] : b[8*j +: 8];
    assign ci = st[j] ? sub : cy[j];

    if (j == NB - 1) begin : g_top_add
      assign sum[8*j +: 8] = a[8*j +: 8] + bo + {7'd0, ci};
    end else begin : g_chain_add
      assign {cy[j+1], sum[8*j +: 8]} = {1'b0, a[8*j +: 8]} + {1'b0, bo} + {8'd0, ci};
    end

    assign shl[8*j +: 8] = {a[8*j +: 7], prv[j] & ~st[j]};
    assign shr[8*j +: 8] = {nxt[j] & ~tp[j], a[8*j+1 +: 7]};
  end

  always_comb begin
    case (kind)
      K_AND:   y = a & b;
      K_OR:    y = a | b;
      K_XOR:   y = a ^ b;
      K_SHL:   y = shl;
      K_SHR:   y = shr;
      default: y = sum;
    endcase
  end

endmodule

// File: rtl/simd_valu.sv
module simd_valu
  import simd_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [FIELD_W-1:0]       in_instr,
  input  logic                     ld_en,
  input  logic [REG_IDX_W-1:0]     ld_idx,
  input  logic [LANES*LANE_W-1:0]  ld_data,
  input  logic [REG_IDX_W-1:0]     rd_idx,
  output logic [LANES*LANE_W-1:0]  rd_data,
  output logic                     wb_valid,
  output logic [REG_IDX_W-1:0]     wb_idx,
  output logic [LANES*LANE_W-1:0]  wb_data
);

  localparam int VW     = LANES * LANE_W;
  localparam int NPAIRS = LANES / 2;
  localparam logic [VW-1:0] BYTE_LSB = {(VW/8){8'h01}};
  localparam logic [VW-1:0] HALF_MSB = {(VW/16){16'h8000}};

  uop_t          uop;
  logic          acc;
  logic [VW-1:0] rf_a, rf_b, opa, opb, res;

  assign in_ready = ~ld_en;
  assign acc      = in_valid & in_ready;

  simd_decode i_dec (
    .field (in_instr),
    .uop   (uop)
  );

  simd_vrf #(.VW(VW)) i_vrf (
    .clk     (clk),
    .rst_n   (rst_n),
    .ra_idx  (uop.src_a),
    .ra_data (rf_a),
    .rb_idx  (uop.src_b),
    .rb_data (rf_b),
    .rc_idx  (rd_idx),
    .rc_data (rd_data),
    .wr_en   (wb_valid),
    .wr_idx  (wb_idx),
    .wr_data (wb_data),
    .ld_en   (ld_en),
    .ld_idx  (ld_idx),
    .ld_data (ld_data)
  );

  // forward the result still waiting to be written
  assign opa = (wb_valid && wb_idx == uop.src_a) ? wb_data : rf_a;
  assign opb = (wb_valid && wb_idx == uop.src_b) ? wb_data : rf_b;

  for (genvar p = 0; p < NPAIRS; p++) begin : g_pair
    simd_pair i_pair (
      .wl   (uop.wl),
      .kind (uop.kind),
      .a    (opa[p*PAIR_W +: PAIR_W]),
      .b    (opb[p*PAIR_W +: PAIR_W]),
      .y    (res[p*PAIR_W +: PAIR_W])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wb_valid <= 1'b0;
      wb_idx   <= '0;
      wb_data  <= '0;
    end else begin
      wb_valid <= acc & uop.wr;
      if (acc && uop.wr) begin
        wb_idx  <= uop.dst;
        wb_data <= res;
      end
    end
  end

  assert_wb_timing_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && uop.wr) |=> (wb_valid && wb_idx == $past(uop.dst)));

  assert_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc && uop.wr) |=> !wb_valid);

  assert_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ld_en) |=> !wb_valid);

  assert_shl_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && uop.wr && uop.kind == K_SHL && uop.wl == WL_8) |=> ((wb_data & BYTE_LSB) == '0));

  assert_shr_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && uop.wr && uop.kind == K_SHR && uop.wl == WL_16) |=> ((wb_data & HALF_MSB) == '0));

endmodule

// File: tb/test_simd_valu.sv
module test_simd_valu;

  localparam int VW = 128;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid, in_ready;
  logic [19:0]   in_instr;
  logic          ld_en;
  logic [3:0]    ld_idx, rd_idx, wb_idx;
  logic [VW-1:0] ld_data, rd_data, wb_data;
  logic          wb_valid;

  always #10 clk = ~clk;

  simd_valu #(.LANES(4)) i_simd_valu (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_instr(in_instr), .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data),
    .rd_idx(rd_idx), .rd_data(rd_data), .wb_valid(wb_valid), .wb_idx(wb_idx),
    .wb_data(wb_data)
  );

  int checks = 0;
  int bad    = 0;
  bit done   = 0;

  logic [VW-1:0] shadow [16];
  logic [3:0]    q_idx  [$];
  logic [VW-1:0] q_data [$];
  string         q_tag  [$];

  task automatic check(input bit ok, input string tag, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit op_writes(input logic [3:0] op);
    return op == 4'b0000 || op == 4'b0010 || op == 4'b1000 || op == 4'b1001 ||
           op == 4'b1010 || op == 4'b1100 || op == 4'b1110;
  endfunction

  function automatic string tag_of(input logic [3:0] op, input logic [1:0] wl);
    if ((op == 4'b0000 || op == 4'b0010) && wl == 2'b11) return "R4";
    case (op)
      4'b0000: return "R2";
      4'b0010: return "R3";
      4'b1100: return "R6";
      4'b1110: return "R7";
      default: return "R5";
    endcase
  endfunction

  function automatic logic [VW-1:0] model(input logic [3:0] op, input logic [1:0] wl,
                                          input logic [VW-1:0] a, input logic [VW-1:0] b);
    int esz;
    logic [VW-1:0] mask, ea, eb, r, y;
    esz  = 8 << wl;
    mask = {VW{1'b1}} >> (VW - esz);
    y    = '0;
    for (int e = 0; e < VW / esz; e++) begin
      ea = (a >> (e * esz)) & mask;
      eb = (b >> (e * esz)) & mask;
      case (op)
        4'b0000: r = (ea + eb) & mask;
        4'b0010: r = (ea - eb) & mask;
        4'b1000: r = ea & eb;
        4'b1001: r = ea | eb;
        4'b1010: r = ea ^ eb;
        4'b1100: r = (ea << 1) & mask;
        default: r = ea >> 1;
      endcase
      y = y | (r << (e * esz));
    end
    return y;
  endfunction

  // driver: offer one field, update the model in program order
  task automatic issue(input logic [1:0] top, input logic [3:0] op, input logic [1:0] wl,
                       input logic [3:0] d, input logic [3:0] sa, input logic [3:0] sb,
                       input string tag);
    logic [VW-1:0] r;
    @(negedge clk);
    in_valid = 1'b1;
    in_instr = {top, wl, op, d, sa, sb};
    if (top == 2'b01 && op_writes(op)) begin
      r = model(op, wl, shadow[sa], shadow[sb]);
      q_idx.push_back(d);
      q_data.push_back(r);
      q_tag.push_back(tag == "" ? tag_of(op, wl) : tag);
      shadow[d] = r;
    end
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic load(input logic [3:0] idx, input logic [VW-1:0] v);
    @(negedge clk);
    in_valid = 1'b0;
    ld_en = 1'b1; ld_idx = idx; ld_data = v;
    @(negedge clk);
    ld_en = 1'b0;
    shadow[idx] = v;
  endtask

  task automatic rdcheck(input logic [3:0] idx, input logic [VW-1:0] exp, input string tag);
    rd_idx = idx;
    #1;
    check(rd_data === exp, tag, rd_data, exp);
  endtask

  // monitor: pop and compare each writeback
  always @(negedge clk) begin
    if (rst_n && !done && wb_valid) begin
      if (q_idx.size() == 0) begin
        check(1'b0, "R8 unexpected writeback", wb_data, '0);
      end else begin
        logic [3:0]    ei;
        logic [VW-1:0] ed;
        string         et;
        ei = q_idx.pop_front();
        ed = q_data.pop_front();
        et = q_tag.pop_front();
        check(wb_idx == ei, {et, " R9 index"}, {124'd0, wb_idx}, {124'd0, ei});
        check(wb_data === ed, et, wb_data, ed);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; bad++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    logic [VW-1:0] old;
    for (int i = 0; i < 16; i++) shadow[i] = '0;
    rst_n = 1'b0; in_valid = 1'b0; in_instr = '0;
    ld_en = 1'b0; ld_idx = '0; ld_data = '0; rd_idx = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R12 reset state
    @(negedge clk);
    check(wb_valid == 1'b0, "R12 wb_valid", {127'd0, wb_valid}, '0);
    check(in_ready == 1'b1, "R11 ready idle", {127'd0, in_ready}, 1);
    for (int i = 0; i < 16; i++) rdcheck(i[3:0], '0, "R12 register");

    load(4'd1, 128'h0000_0000_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF);
    load(4'd2, 128'h0000_0001_0000_0001_0000_0001_0000_0001);
    load(4'd3, 128'h8001_7FFF_00FF_FF00_1234_5678_9ABC_DEF0);
    load(4'd4, 128'hFFFF_FFFF_0000_0000_0F0F_F0F0_8080_0101);
    @(negedge clk);
    rdcheck(4'd3, shadow[3], "R11 load");

    // R1 sweep of every op code and length, back to back
    for (int pass = 0; pass < 2; pass++) begin
      for (int op = 0; op < 16; op++) begin
        for (int wl = 0; wl < 4; wl++) begin
          logic [3:0] sa, sb;
          if ((wl % 2) == pass) begin sa = 4'd1; sb = 4'd2; end
          else                  begin sa = 4'd4; sb = 4'd3; end
          if (pass == 1) begin logic [3:0] t; t = sa; sa = sb; sb = t; end
          issue(2'b01, op[3:0], wl[1:0], 4'(8 + ((op * 4 + wl) % 8)), sa, sb, "");
        end
      end
    end
    idle();
    @(negedge clk);
    for (int i = 0; i < 16; i++) rdcheck(i[3:0], shadow[i], "R1 register contents");

    // R9 write timing
    old = shadow[5];
    issue(2'b01, 4'b0000, 2'b10, 4'd5, 4'd1, 4'd2, "R9");
    idle();
    rdcheck(4'd5, old, "R9 not yet written");
    @(negedge clk);
    rdcheck(4'd5, shadow[5], "R9 written");

    // R10 dependent chain
    issue(2'b01, 4'b0000, 2'b10, 4'd9,  4'd1,  4'd2,  "R10");
    issue(2'b01, 4'b0000, 2'b00, 4'd10, 4'd9,  4'd9,  "R10");
    issue(2'b01, 4'b1010, 2'b11, 4'd9,  4'd10, 4'd1,  "R10");
    issue(2'b01, 4'b0010, 2'b01, 4'd11, 4'd9,  4'd10, "R10");
    issue(2'b01, 4'b1100, 2'b11, 4'd11, 4'd11, 4'd11, "R10");
    idle();
    @(negedge clk);
    rdcheck(4'd11, shadow[11], "R10 chain end");

    // R8 non-writing fields
    old = shadow[12];
    issue(2'b00, 4'b0000, 2'b10, 4'd12, 4'd1, 4'd2, "R8");
    issue(2'b10, 4'b0000, 2'b10, 4'd12, 4'd1, 4'd2, "R8");
    issue(2'b11, 4'b1000, 2'b10, 4'd12, 4'd1, 4'd2, "R8");
    issue(2'b01, 4'b1011, 2'b10, 4'd12, 4'd3, 4'd4, "R8");
    issue(2'b01, 4'b0001, 2'b00, 4'd12, 4'd3, 4'd4, "R8");
    issue(2'b01, 4'b1111, 2'b11, 4'd12, 4'd3, 4'd4, "R8");
    idle();
    @(negedge clk);
    rdcheck(4'd12, old, "R8 register untouched");

    // R11 stall: instruction held while loading its source
    @(negedge clk);
    ld_en = 1'b1; ld_idx = 4'd6; ld_data = 128'h1111_2222_3333_4444_5555_6666_7777_8888;
    in_valid = 1'b1; in_instr = {2'b01, 2'b10, 4'b0000, 4'd7, 4'd6, 4'd6};
    #1;
    check(in_ready == 1'b0, "R11 ready low", {127'd0, in_ready}, '0);
    @(negedge clk);
    check(wb_valid == 1'b0, "R11 held not taken", {127'd0, wb_valid}, '0);
    ld_en = 1'b0;
    shadow[6] = ld_data;
    shadow[7] = model(4'b0000, 2'b10, shadow[6], shadow[6]);
    q_idx.push_back(4'd7); q_data.push_back(shadow[7]); q_tag.push_back("R11");
    idle();
    @(negedge clk);
    rdcheck(4'd7, shadow[7], "R11 after stall");

    // R11 load beats a pending writeback to the same register
    issue(2'b01, 4'b0000, 2'b10, 4'd5, 4'd3, 4'd4, "R11");
    @(negedge clk);
    in_valid = 1'b0;
    ld_en = 1'b1; ld_idx = 4'd5; ld_data = 128'hDEAD_BEEF_0000_1111_2222_3333_4444_5555;
    @(negedge clk);
    ld_en = 1'b0;
    shadow[5] = ld_data;
    rdcheck(4'd5, shadow[5], "R11 load wins");

    @(negedge clk);
    for (int i = 0; i < 16; i++) rdcheck(i[3:0], shadow[i], "R9 final contents");
    check(q_idx.size() == 0, "R9 all writebacks seen", VW'(q_idx.size()), '0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule